// File: doc/BRIEF.md
# Burst-Mode Laser Bias Power Controller

This block is the digital loop that sets the bias current of a burst-mode laser transmitter. It produces a 10-bit code for an external bias DAC. A single comparator bit reports whether the monitor-photodiode feedback sits below or above the power set point. During transmit bursts that are long enough, an up/down integrator walks the code one LSB per sample tick to close the loop.

Between bursts the code is held. When the transmitter keeps sending bursts too short to give a sample, the loop stops trusting itself. It then falls back to a bias value taken from a temperature-indexed table, which firmware fills through a simple write port. The same table supplies the whole bias in open-loop operation. It also seeds the integrator whenever closed-loop operation begins.

Top module: `burst_bias_ctrl`

## Requirements
- R1: The operating mode is chosen from two control bits. `mode_open`=1 selects open loop and wins over `mode_closed`. `mode_closed`=1 alone selects forced closed loop. Both at 0 select autodetect, which is the mode in effect after reset. `integ_en` reflects the resulting integrator enable one cycle after the inputs change.
- R2: In open loop, `integ_en` is 0, `dac_code` follows the aligned table value, and bursts and feedback have no effect on it.
- R3: The 8-bit table value is aligned into the 10-bit code by left shift. With `fs_half`=0 its bit 7 lands on code bit 9 (value×4). With `fs_half`=1 it lands on code bit 8 (value×2).
- R4: The table has 72 entries of 2 °C each. `lut_addr` = (temp_c + 40) >> 1, where temp_c is a signed 8-bit reading in °C, clamped to 0 below -40 °C and to 71 at or above 102 °C. It is registered, so it appears one cycle after `temp_c` and its data one cycle later. Writes are synchronous through `lut_wr_en`/`lut_wr_addr`/`lut_wr_data`.
- R5: The sample period is P = (sample_rate+1)×16 cycles, counted from the start of a burst. A burst is qualified if `burst_on` stays high for at least P consecutive cycles, and short otherwise.
- R6: While the integrator is enabled, each sample tick raises the code by 1 when `fb_below`=1 and lowers it by 1 when `fb_below`=0.
- R7: The integrated code saturates at 0 and at 1023.
- R8: The first tick after reset, or after the integrator has been disabled, loads the aligned table value instead of stepping. Stepping starts at the next tick.
- R9: In autodetect, 32 consecutive short bursts disable the integrator (`integ_en`=0). The code then tracks the aligned table value.
- R10: The short-burst run saturates at 32 rather than wrapping. Any qualified burst clears the run and re-enables the integrator in autodetect.
- R11: Outside bursts, an enabled integrator holds `dac_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_on | input | 1 | High while a transmit burst is active |
| sample_rate | input | 4 | Sample period select, P=(n+1)×16 cycles |
| fb_below | input | 1 | 1 when feedback is below the set point |
| temp_c | input | 8 | Signed temperature in °C |
| mode_open | input | 1 | Force open-loop operation |
| mode_closed | input | 1 | Force closed-loop operation |
| fs_half | input | 1 | Align table MSB to DAC bit 8 instead of bit 9 |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_addr | input | 7 | Table write address |
| lut_wr_data | input | 8 | Table write data |
| dac_code | output | 10 | Bias DAC code |
| integ_en | output | 1 | Integrator enabled |
| lut_addr | output | 7 | Table index in use |

## Verification
The hardest state to reach from the ports is fallback and recovery in autodetect. It needs a run of exactly 31 short bursts with the code unchanged, a 32nd that trips the fallback, and then enough further short bursts to expose a counter that wraps. The stimulus first moves the code away from the table value with one qualified burst. It then issues 72 short bursts in a row. Next it raises the sample rate so that a 20-cycle burst, which would have qualified at the lowest rate, is still short. A 32-cycle burst then re-enables the loop, and a final burst shows the seed load followed by one step.

// File: rtl/bbpc_pkg.sv
package bbpc_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO   = 2'd0,
    MODE_OPEN   = 2'd1,
    MODE_CLOSED = 2'd2
  } bias_mode_e;

  // open loop has priority over forced closed loop
  function automatic bias_mode_e pick_mode(input logic open_i, input logic closed_i);
    if (open_i)   return MODE_OPEN;
    if (closed_i) return MODE_CLOSED;
    return MODE_AUTO;
  endfunction

endpackage

// File: rtl/bbpc_burst_qual.sv
module bbpc_burst_qual #(
  parameter int SR_W      = 4,
  parameter int TICK_UNIT = 16,
  parameter int RUN_LIMIT = 32,
  parameter int RUN_W     = $clog2(RUN_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_on,
  input  logic [SR_W-1:0]  sample_rate,
  output logic             tick,
  output logic [RUN_W-1:0] short_run
);

  localparam int PER_W = $clog2(TICK_UNIT * (1 << SR_W));

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per_m1;
  logic             burst_q;
  logic             had_tick;
  logic             burst_end;

  always_comb begin
    per_m1 = PER_W'((int'(sample_rate) + 1) * TICK_UNIT - 1);
  end

  assign tick      = burst_on && (cnt == per_m1);
  assign burst_end = burst_q && !burst_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      had_tick  <= 1'b0;
      burst_q   <= 1'b0;
      short_run <= '0;
    end else begin
      burst_q <= burst_on;
      if (burst_on) begin
        if (tick) begin
          cnt      <= '0;
          had_tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt      <= '0;
        had_tick <= 1'b0;
      end
      if (tick) begin
        short_run <= '0;
      end else if (burst_end && !had_tick && (short_run != RUN_W'(RUN_LIMIT))) begin
        short_run <= short_run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bbpc_bias_lut.sv
module bbpc_bias_lut #(
  parameter int TEMP_W    = 8,
  parameter int LUT_W     = 8,
  parameter int DEPTH     = 72,
  parameter int TEMP_BASE = -40,
  parameter int STEP_LOG2 = 1,
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [TEMP_W-1:0] temp_c,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [LUT_W-1:0]         wr_data,
  output logic [AW-1:0]            rd_addr,
  output logic [LUT_W-1:0]         rd_data
);

  logic [LUT_W-1:0] mem [DEPTH];
  int               off_c;
  int               slot_c;
  logic [AW-1:0]    idx_c;

  always_comb begin
    off_c  = int'(temp_c) - TEMP_BASE;
    slot_c = off_c >>> STEP_LOG2;
    if (off_c < 0)              idx_c = '0;
    else if (slot_c > DEPTH - 1) idx_c = AW'(DEPTH - 1);
    else                         idx_c = AW'(slot_c);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_addr <= '0;
    else     rd_addr <= idx_c;
  end

  // plain write / registered read so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/bbpc_integrator.sv
module bbpc_integrator #(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             fb_below,
  input  logic [DAC_W-1:0] seed_code,
  output logic [DAC_W-1:0] code,
  output logic             seed_pend
);

  localparam logic [DAC_W-1:0] CODE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      seed_pend <= 1'b1;
    end else if (!en) begin
      code      <= seed_code;
      seed_pend <= 1'b1;
    end else if (tick) begin
      if (seed_pend) begin
        code      <= seed_code;
        seed_pend <= 1'b0;
      end else if (fb_below) begin
        if (code != CODE_MAX) code <= code + 1'b1;
      end else begin
        if (code != '0) code <= code - 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_bias_ctrl.sv
module burst_bias_ctrl #(
  parameter int DAC_W     = 10,
  parameter int LUT_W     = 8,
  parameter int LUT_DEPTH = 72,
  parameter int TEMP_W    = 8,
  parameter int TEMP_BASE = -40,
  parameter int STEP_LOG2 = 1,
  parameter int SR_W      = 4,
  parameter int TICK_UNIT = 16,
  parameter int RUN_LIMIT = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     burst_on,
  input  logic [SR_W-1:0]          sample_rate,
  input  logic                     fb_below,
  input  logic signed [TEMP_W-1:0] temp_c,
  input  logic                     mode_open,
  input  logic                     mode_closed,
  input  logic                     fs_half,
  input  logic                     lut_wr_en,
  input  logic [$clog2(LUT_DEPTH)-1:0] lut_wr_addr,
  input  logic [LUT_W-1:0]         lut_wr_data,
  output logic [DAC_W-1:0]         dac_code,
  output logic                     integ_en,
  output logic [$clog2(LUT_DEPTH)-1:0] lut_addr
);

  import bbpc_pkg::*;

  localparam int AW    = $clog2(LUT_DEPTH);
  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam int PAD   = DAC_W - LUT_W;

  logic             tick;
  logic [RUN_W-1:0] short_run;
  logic [LUT_W-1:0] lut_data;
  logic [DAC_W-1:0] seed_full;
  logic [DAC_W-1:0] seed_code;
  logic             seed_pend;
  logic             en_next;
  bias_mode_e       mode_c;

  bbpc_burst_qual #(
    .SR_W(SR_W), .TICK_UNIT(TICK_UNIT), .RUN_LIMIT(RUN_LIMIT), .RUN_W(RUN_W)
  ) u_qual (
    .clk(clk), .rst(rst), .burst_on(burst_on), .sample_rate(sample_rate),
    .tick(tick), .short_run(short_run)
  );

  bbpc_bias_lut #(
    .TEMP_W(TEMP_W), .LUT_W(LUT_W), .DEPTH(LUT_DEPTH),
    .TEMP_BASE(TEMP_BASE), .STEP_LOG2(STEP_LOG2), .AW(AW)
  ) u_lut (
    .clk(clk), .rst(rst), .temp_c(temp_c),
    .wr_en(lut_wr_en), .wr_addr(lut_wr_addr), .wr_data(lut_wr_data),
    .rd_addr(lut_addr), .rd_data(lut_data)
  );

  // table value placed with its MSB on DAC MSB, or one bit lower
  assign seed_full = {lut_data, {PAD{1'b0}}};
  assign seed_code = fs_half ? (seed_full >> 1) : seed_full;

  always_comb begin
    mode_c = pick_mode(mode_open, mode_closed);
    unique case (mode_c)
      MODE_OPEN:   en_next = 1'b0;
      MODE_CLOSED: en_next = 1'b1;
      default:     en_next = (short_run < RUN_W'(RUN_LIMIT));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) integ_en <= 1'b0;
    else     integ_en <= en_next;
  end

  bbpc_integrator #(
    .DAC_W(DAC_W)
  ) u_integ (
    .clk(clk), .rst(rst), .en(integ_en), .tick(tick), .fb_below(fb_below),
    .seed_code(seed_code), .code(dac_code), .seed_pend(seed_pend)
  );

endmodule

// File: rtl/bbpc_checker.sv
module bbpc_checker #(
  parameter int DAC_W     = 10,
  parameter int AW        = 7,
  parameter int DEPTH     = 72,
  parameter int RUN_W     = 6,
  parameter int RUN_LIMIT = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             burst_on,
  input logic             mode_open,
  input logic             mode_closed,
  input logic             integ_en,
  input logic             seed_pend,
  input logic [DAC_W-1:0] dac_code,
  input logic [AW-1:0]    lut_addr,
  input logic [RUN_W-1:0] short_run
);

  // R2: open loop keeps the integrator off
  a_r2_open_no_integ: assert property (@(posedge clk) disable iff (rst)
    $past(mode_open) |-> !integ_en);

  // R4: index never leaves the table
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(lut_addr) < DEPTH);

  // R6: once seeded, the code moves at most one LSB per cycle
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    ($past(integ_en) && !$past(seed_pend)) |->
      ((dac_code == $past(dac_code)) ||
       ((DAC_W+1)'(dac_code) == (DAC_W+1)'($past(dac_code)) + 1'b1) ||
       ((DAC_W+1)'(dac_code) + 1'b1 == (DAC_W+1)'($past(dac_code)))));

  // R9: a full short run disables the integrator unless closed loop is forced
  a_r9_fallback: assert property (@(posedge clk) disable iff (rst)
    ((short_run == RUN_W'(RUN_LIMIT)) && !mode_closed) |=> !integ_en);

  // R10: the short-burst run never exceeds its limit
  a_r10_run_saturates: assert property (@(posedge clk) disable iff (rst)
    short_run <= RUN_W'(RUN_LIMIT));

  // R11: no movement between bursts while enabled
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(integ_en) && !$past(burst_on)) |-> $stable(dac_code));

endmodule

bind burst_bias_ctrl bbpc_checker #(
  .DAC_W(DAC_W), .AW(AW), .DEPTH(LUT_DEPTH), .RUN_W(RUN_W), .RUN_LIMIT(RUN_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .burst_on(burst_on), .mode_open(mode_open),
  .mode_closed(mode_closed), .integ_en(integ_en), .seed_pend(seed_pend),
  .dac_code(dac_code), .lut_addr(lut_addr), .short_run(short_run)
);

// File: tb/burst_bias_ctrl_tb.sv
module burst_bias_ctrl_tb;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              burst_on = 1'b0;
  logic [3:0]        sample_rate = 4'd0;
  logic              fb_below = 1'b0;
  logic signed [7:0] temp_c = 8'sd25;
  logic              mode_open = 1'b0;
  logic              mode_closed = 1'b0;
  logic              fs_half = 1'b0;
  logic              lut_wr_en = 1'b0;
  logic [6:0]        lut_wr_addr = '0;
  logic [7:0]        lut_wr_data = '0;
  logic [9:0]        dac_code;
  logic              integ_en;
  logic [6:0]        lut_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_bias_ctrl u_dut (
    .clk(clk), .rst(rst), .burst_on(burst_on), .sample_rate(sample_rate),
    .fb_below(fb_below), .temp_c(temp_c), .mode_open(mode_open),
    .mode_closed(mode_closed), .fs_half(fs_half), .lut_wr_en(lut_wr_en),
    .lut_wr_addr(lut_wr_addr), .lut_wr_data(lut_wr_data),
    .dac_code(dac_code), .integ_en(integ_en), .lut_addr(lut_addr)
  );

  // {temperature, expected table index}
  localparam logic [14:0] VEC [11] = '{
    {8'h80, 7'd0}, {8'hD7, 7'd0}, {8'hD8, 7'd0}, {8'hD9, 7'd0},
    {8'hDA, 7'd1}, {8'h00, 7'd20}, {8'h19, 7'd32}, {8'h65, 7'd70},
    {8'h66, 7'd71}, {8'h67, 7'd71}, {8'h7F, 7'd71}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input int len, input logic fb);
    @(negedge clk);
    burst_on = 1'b1;
    fb_below = fb;
    repeat (len) @(negedge clk);
    burst_on = 1'b0;
    idle(4);
  endtask

  task automatic write_lut(input int a, input int d);
    @(negedge clk);
    lut_wr_en   = 1'b1;
    lut_wr_addr = 7'(a);
    lut_wr_data = 8'(d);
    @(negedge clk);
    lut_wr_en   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 reset dac", int'(dac_code), 0);
    check("R1 reset integ_en", int'(integ_en), 0);
    check("R4 reset lut_addr", int'(lut_addr), 0);
    rst = 1'b0;
    idle(3);
    check("R1 auto default integ_en", int'(integ_en), 1);
    check("R11 no burst hold", int'(dac_code), 0);

    for (int i = 0; i < 72; i++) write_lut(i, i * 3 + 5);

    // table walk in open loop: R4 index, R2/R3 code = value*4
    mode_open = 1'b1;
    for (int k = 0; k < 11; k++) begin
      temp_c = VEC[k][14:7];
      idle(6);
      check("R4 lut_addr", int'(lut_addr), int'(VEC[k][6:0]));
      check("R2 open dac", int'(dac_code), (int'(VEC[k][6:0]) * 3 + 5) * 4);
    end

    write_lut(32, 8'h40);
    write_lut(71, 8'hFF);
    write_lut(0, 8'h01);
    temp_c = 8'sd25;
    idle(6);
    check("R2 open integ_en", int'(integ_en), 0);
    check("R2 open dac", int'(dac_code), 256);
    burst(80, 1'b1);
    check("R2 burst ignored", int'(dac_code), 256);
    fs_half = 1'b1;
    idle(3);
    check("R3 half scale", int'(dac_code), 128);
    fs_half = 1'b0;
    idle(3);
    mode_closed = 1'b1;
    idle(3);
    check("R1 open wins", int'(integ_en), 0);
    mode_open = 1'b0;
    idle(3);
    check("R1 closed integ_en", int'(integ_en), 1);

    // closed loop: seed then 4 up steps, then 2 down
    burst(80, 1'b1);
    check("R8 R6 seed+4", int'(dac_code), 260);
    burst(32, 1'b0);
    check("R6 down 2", int'(dac_code), 258);
    idle(20);
    check("R11 hold", int'(dac_code), 258);
    for (int s = 0; s < 40; s++) burst(10, 1'b1);
    check("R1 closed ignores shorts", int'(integ_en), 1);
    check("R5 short no step", int'(dac_code), 258);

    // saturation at top
    mode_open = 1'b1;
    temp_c = 8'sd110;
    idle(6);
    check("R4 clamp high dac", int'(dac_code), 1020);
    mode_open = 1'b0;
    idle(3);
    burst(160, 1'b1);
    check("R7 top saturate", int'(dac_code), 1023);
    // saturation at bottom
    mode_open = 1'b1;
    temp_c = -8'sd50;
    idle(6);
    check("R4 clamp low dac", int'(dac_code), 4);
    mode_open = 1'b0;
    idle(3);
    burst(160, 1'b0);
    check("R7 bottom saturate", int'(dac_code), 0);

    // autodetect fallback and recovery
    mode_open = 1'b1;
    temp_c = 8'sd25;
    idle(6);
    mode_open = 1'b0;
    mode_closed = 1'b0;
    idle(3);
    burst(48, 1'b1);
    check("R6 auto steps", int'(dac_code), 258);
    for (int s = 0; s < 31; s++) burst(10, 1'b0);
    check("R9 31 shorts enabled", int'(integ_en), 1);
    check("R9 31 shorts dac", int'(dac_code), 258);
    burst(10, 1'b0);
    check("R9 32 shorts disabled", int'(integ_en), 0);
    check("R9 table value", int'(dac_code), 256);
    for (int s = 0; s < 40; s++) burst(10, 1'b0);
    check("R10 no wrap", int'(integ_en), 0);
    sample_rate = 4'd1;
    burst(20, 1'b1);
    check("R5 rate 1 short", int'(integ_en), 0);
    burst(32, 1'b1);
    check("R10 re-enable", int'(integ_en), 1);
    check("R10 dac after re-enable", int'(dac_code), 256);
    burst(64, 1'b1);
    check("R8 reseed then step", int'(dac_code), 257);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule